// File: doc/BRIEF.md
# Sixteen-Bit-Per-Clock Trinomial Random Word Generator

This block produces one 16-bit pseudo-random word per advance from a 63-bit linear feedback shift register that obeys the two-tap recurrence x[n] = x[n-62] xor x[n-63]. Each new bit costs a single two-input xor. Sixteen serial steps of that recurrence are unrolled into one clock edge, so the generator delivers a full fresh word on every advance. It is meant to sit next to Monte Carlo comparators that need a new uniform word each cycle.

The 63 state bits are not kept as one long chain. They are split into sixteen short lanes of at most four bits. Lane k holds the window positions k, k+16, k+32 and k+48, so lane 15 has only three bits. On an advance, every lane shifts down by one place and takes one freshly computed bit at its top. All lanes load on the same edge. The output word is the bottom bit of every lane, which is the oldest sixteen bits of the current window.

While synchronous reset is high, the seed is loaded on every clock. An all-zero seed would lock the generator at zero, so it is replaced by a fixed nonzero constant. Outside reset, the state moves only on cycles where advance is high.

Top module: `lfsr16_gen`

## Requirements
- R1: On a rising clock edge with `rst` high and a nonzero `seed`, the window is loaded so that window position j equals `seed[j]`. One edge later, `randWord` equals `seed[15:0]`.
- R2: On a rising clock edge with `rst` high and `seed` equal to zero, the window is loaded with the constant SAFE_SEED (default 63'h1), and `randWord` then reads SAFE_SEED[15:0] (0x0001).
- R3: On an edge with `rst` low and `advance` low, the state does not change, and `randWord` keeps its value.
- R4: An edge with `rst` low and `advance` high moves the window exactly sixteen steps of the serial recurrence. With window w[0..62] (w[0] oldest), each serial step appends w[0] xor w[1] at position 62 and drops w[0].
- R5: `randWord` bit i equals window position i, so bit 0 is the oldest bit of the window.
- R6: Outside reset, the window is never all zero.
- R7: The word sequence depends only on the state. Reloading the same seed and applying the same advances reproduces the same words.
- R8: `rst` takes priority over `advance`. An edge with both high loads the seed and does not step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset; loads the seed while high |
| advance | input | 1 | Step sixteen serial positions on this edge |
| seed | input | 63 | Initial window; bit j goes to window position j |
| randWord | output | 16 | Current sixteen oldest window bits |

## Verification
The bench runs a bit-serial model of the recurrence from the same seed and compares every word. A wrong lane-to-position mapping, an off-by-one tap or a lane with the wrong depth would diverge from that model within a few advances. Directed cases cover:
- The zero seed. A generator that skipped the substitution would output zero forever.
- Reset and advance together. A design that let advance win would show a stepped word instead of the seed.
- Long idle stretches. A design that leaked a step would drift from the model.

Reloading a seed and replaying the advances catches any hidden state outside the window.

// File: rtl/lfsr16_pkg.sv
package lfsr16_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } lfsrStrobe_t;

  localparam int DEF_STATE_W = 63;
  localparam int DEF_WORD_W  = 16;
endpackage

// File: rtl/lfsr16_ctrl.sv
module lfsr16_ctrl
  import lfsr16_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        advance,
  output lfsrStrobe_t strobe
);
  // Reset dominates: a load cycle never steps.
  always_comb begin
    strobe.load = rst;
    strobe.step = advance & ~rst;
  end

  p_reset_prio_r8: assert property (@(posedge clk) !(strobe.load && strobe.step));
endmodule

// File: rtl/lfsr16_lane.sv
module lfsr16_lane #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             load,
  input  logic             step,
  input  logic [DEPTH-1:0] loadVal,
  input  logic             inBit,
  output logic [DEPTH-1:0] laneQ
);
  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (load)      laneQ <= loadVal;
        else if (step) laneQ <= inBit;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (load)      laneQ <= loadVal;
        else if (step) laneQ <= {inBit, laneQ[DEPTH-1:1]};
      end
    end
  endgenerate
endmodule

// File: rtl/lfsr16_dpath.sv
module lfsr16_dpath
  import lfsr16_pkg::*;
#(
  parameter int          STATE_W   = DEF_STATE_W,
  parameter int          WORD_W    = DEF_WORD_W,
  parameter logic [62:0] SAFE_SEED = 63'h1
) (
  input  logic               clk,
  input  logic               rst,
  input  lfsrStrobe_t        strobe,
  input  logic [STATE_W-1:0] seed,
  output logic [WORD_W-1:0]  randWord
);
  localparam int FRESH_BASE = STATE_W - WORD_W; // first window position refilled per step

  logic [STATE_W-1:0] window;
  logic [STATE_W-1:0] seedEff;

  assign seedEff = (seed == '0) ? SAFE_SEED[STATE_W-1:0] : seed;

  generate
    for (genvar k = 0; k < WORD_W; k++) begin : g_lane
      localparam int DEPTH = (STATE_W - k + WORD_W - 1) / WORD_W;
      localparam int TOPJ  = k + WORD_W * (DEPTH - 1);
      localparam int SRC   = TOPJ - FRESH_BASE;
      logic [DEPTH-1:0] laneQ;
      logic [DEPTH-1:0] loadVal;
      logic             inBit;

      assign inBit = window[SRC] ^ window[SRC+1];

      for (genvar i = 0; i < DEPTH; i++) begin : g_pos
        assign loadVal[i]          = seedEff[k + WORD_W*i];
        assign window[k + WORD_W*i] = laneQ[i];
      end

      lfsr16_lane #(.DEPTH(DEPTH)) u_lane (
        .clk     (clk),
        .load    (strobe.load),
        .step    (strobe.step),
        .loadVal (loadVal),
        .inBit   (inBit),
        .laneQ   (laneQ)
      );
    end
  endgenerate

  assign randWord = window[WORD_W-1:0];

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !strobe.step |=> $stable(window));
  p_shift_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.step |=> window[FRESH_BASE-1:0] == $past(window[STATE_W-1:WORD_W]));
  p_fresh_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.step |=> window[STATE_W-1:FRESH_BASE] ==
      $past(window[WORD_W-1:0] ^ window[WORD_W:1]));
  p_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    window != '0);
endmodule

// File: rtl/lfsr16_gen.sv
module lfsr16_gen
  import lfsr16_pkg::*;
#(
  parameter int          STATE_W   = DEF_STATE_W,
  parameter int          WORD_W    = DEF_WORD_W,
  parameter logic [62:0] SAFE_SEED = 63'h1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               advance,
  input  logic [STATE_W-1:0] seed,
  output logic [WORD_W-1:0]  randWord
);
  lfsrStrobe_t strobe;

  lfsr16_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .advance (advance),
    .strobe  (strobe)
  );

  lfsr16_dpath #(
    .STATE_W   (STATE_W),
    .WORD_W    (WORD_W),
    .SAFE_SEED (SAFE_SEED)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .seed     (seed),
    .randWord (randWord)
  );

  p_load_seed_r1: assert property (@(posedge clk)
    (rst && seed != '0) |=> randWord == $past(seed[WORD_W-1:0]));
  p_zero_seed_r2: assert property (@(posedge clk)
    (rst && seed == '0) |=> randWord == SAFE_SEED[WORD_W-1:0]);
endmodule

// File: tb/test_lfsr16_gen.sv
module test_lfsr16_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        advance = 1'b0;
  logic [62:0] seed = 63'h0;
  logic [15:0] randWord;

  int vectors = 0;
  int fails = 0;
  logic [62:0] model;
  logic [15:0] saved [32];

  always #10 clk = ~clk;

  lfsr16_gen i_lfsr16_gen (
    .clk(clk), .rst(rst), .advance(advance), .seed(seed), .randWord(randWord)
  );

  function automatic logic [62:0] serialSteps(input logic [62:0] w, input int n);
    logic [62:0] r = w;
    for (int s = 0; s < n; s++) r = {r[0] ^ r[1], r[62:1]};
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    vectors++;
    if (randWord !== exp) begin
      fails++;
      $display("FAIL %s: randWord=%h expected=%h", req, randWord, exp);
    end
  endtask

  task automatic cycle(input logic r, input logic a);
    rst = r; advance = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(input logic [62:0] s);
    seed = s;
    cycle(1'b1, 1'b0);
    model = (s == 63'h0) ? 63'h1 : s;
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);

    // R1: reset loads seed, word is seed low bits
    doReset(63'h1234_5678_9ABC_DEF0);
    check("R1", 16'hDEF0);
    // R5: bit order equals window positions
    check("R5", model[15:0]);

    // R3: idle keeps the word
    for (int i = 0; i < 5; i++) begin
      cycle(1'b0, 1'b0);
      check("R3", model[15:0]);
    end

    // R4: single advances against the serial model
    for (int i = 0; i < 20; i++) begin
      cycle(1'b0, 1'b1);
      model = serialSteps(model, 16);
      check("R4", model[15:0]);
    end

    // R8: reset with advance asserted loads, no step
    seed = 63'h7AAA_5555_0F0F_C3C3;
    cycle(1'b1, 1'b1);
    model = seed;
    check("R8", 16'hC3C3);

    // R2: zero seed replaced by constant, then sequence follows constant
    doReset(63'h0);
    check("R2", 16'h0001);
    for (int i = 0; i < 8; i++) begin
      cycle(1'b0, 1'b1);
      model = serialSteps(model, 16);
      check("R2", model[15:0]);
    end

    // R4, R6: random seeds, random advance pattern, long runs
    for (int s = 0; s < 6; s++) begin
      doReset({$urandom(), $urandom()} & 63'h7FFF_FFFF_FFFF_FFFF);
      for (int i = 0; i < 2000; i++) begin
        logic a = ($urandom_range(3) != 0);
        cycle(1'b0, a);
        if (a) model = serialSteps(model, 16);
        check("R4", model[15:0]);
        if (model == 63'h0) begin
          fails++;
          $display("FAIL R6: model window zero, randWord=%h expected nonzero", randWord);
        end
      end
    end

    // R6: sparse seed with single bit at the top
    doReset(63'h4000_0000_0000_0000);
    check("R1", 16'h0000);
    for (int i = 0; i < 300; i++) begin
      cycle(1'b0, 1'b1);
      model = serialSteps(model, 16);
      check("R6", model[15:0]);
    end

    // R7: replay from the same seed reproduces the same words
    doReset(63'h0DEC_AF00_BEEF_0123);
    for (int i = 0; i < 32; i++) begin
      cycle(1'b0, 1'b1);
      saved[i] = randWord;
    end
    doReset(63'h0DEC_AF00_BEEF_0123);
    for (int i = 0; i < 32; i++) begin
      if (i % 3 == 0) begin
        cycle(1'b0, 1'b0);
      end
      cycle(1'b0, 1'b1);
      check("R7", saved[i]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: randWord=%h expected run to finish", randWord);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule